// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block runs every access to an external asynchronous static RAM of 512K sixteen-bit words from a synchronous clock domain. A host issues a request with a valid/ready handshake. Each request carries a word address, write data, a two-bit byte-lane mask and a read/write flag. The controller then drives the memory's select, write-strobe, output-enable and byte-lane pins. It also drives the address bus and a direction control for the shared data bus.

Every phase of an access has a minimum duration in nanoseconds. A single clock-period parameter turns each duration into a cycle count, using the ceiling of the time divided by the period and never less than one cycle. A read holds the output enable low long enough for address access time and output-enable access time to elapse, and registers the bus on its last cycle. A write sets up the address, pulses the write strobe, keeps chip and lane enables active for a hold interval after the strobe rises, and pads the access out to the minimum cycle time. After any read, the controller waits out the memory's output turn-off time before it starts anything else.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: When no access is in progress, and from reset, the memory sits in standby. In that state memCe1N=1, memCe2=0, memBeN=2'b11, memWeN=1, memOeN=1 and memDoe=0.
- R2: reqReady is high only when the controller is idle. A request is taken on a clock edge where reqValid and reqReady are both high, and reqReady is low in the next cycle. The address, data, lane mask and direction are captured at that edge, and later changes to the request inputs have no effect on the access.
- R3: A read asserts memCe1N=0, memCe2=1, memWeN=1 and memOeN=0 for exactly ceil(max(70,70,35)/CLK_NS) cycles (14 at 5 ns). The bus is registered on the last of those cycles. ackValid is high for exactly one cycle, the next one, with that word on ackRdata.
- R4: memBeN bit 0 controls the low byte (data bits 7:0) and bit 1 controls the high byte (data bits 15:8). During an access, a lane's enable is low only if the matching bit of reqBe was 1 at acceptance. In a write, only the enabled lanes of the stored word change.
- R5: In a write, memOeN stays high throughout. memWeN is low for max(ceil(50/CLK_NS), ceil(30/CLK_NS)) cycles (10 at 5 ns). Before that comes a setup of max(1, ceil(60/CLK_NS) minus the pulse) cycles (2 at 5 ns) with the chip selected and memWeN high.
- R6: A write ends on the rising edge of memWeN. At that edge both chip enables are still active. In the cycle after it, the chip and lane enables and memDoe remain asserted. memDoe is high in every cycle where memWeN is low. memAddr and memDout do not change while memWeN is low.
- R7: After memOeN rises, memDoe stays low for at least ceil(25/CLK_NS) cycles (5 at 5 ns).
- R8: reqReady stays low for at least ceil(70/CLK_NS) cycles (14 at 5 ns) after a request is accepted, for both reads and writes.
- R9: Each accepted write produces exactly one single-cycle ackValid pulse, in the cycle after the write hold. Acknowledges arrive in request order.
- R10: memDoe is never high while memOeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle, ready to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| ackValid | output | 1 | One-cycle completion pulse |
| ackRdata | output | 16 | Word captured by the last read |
| memAddr | output | 19 | Memory address bus |
| memDout | output | 16 | Data driven toward the memory |
| memDin | input | 16 | Data returned by the memory |
| memDoe | output | 1 | Enable for the data-bus drivers |
| memCe1N | output | 1 | Chip enable 1, active low |
| memCe2 | output | 1 | Chip enable 2, active high |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Lane enables, active low, bit 0 low byte |

## Verification
A wrong state or counter value shows up at the pins within a single access. A phase that is cut short or stretched changes the measured memWeN or memOeN run length. If a phase is skipped, the setup count or hold check fails. The bench memory model returns a poison word until a full access time has passed, so a read captured one cycle early shows up as a wrong ackRdata on that same request. A lost lane mask or a badly latched address corrupts a later read-back, so the scoreboard catches it within a few requests.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    logic load;     // capture host request
    logic select;   // chip and lane enables active
    logic rdEn;     // output enable active
    logic wrEn;     // write strobe active
    logic drive;    // data-bus drivers on
    logic capture;  // register memory data
    logic done;     // raise acknowledge next cycle
  } strobe_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 14,
  parameter int TURN_CYC = 5,
  parameter int WSU_CYC  = 2,
  parameter int WPW_CYC  = 10,
  parameter int WHD_CYC  = 1,
  parameter int WREC_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int TOTAL = RD_CYC + TURN_CYC + WSU_CYC + WPW_CYC + WHD_CYC + WREC_CYC;
  localparam int CNT_W = $clog2(TOTAL + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_WSETUP, S_WPULSE, S_WHOLD, S_WREC
  } state_t;

  state_t            state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic              last;

  assign last     = (cnt == '0);
  assign reqReady = (state == S_IDLE);

  always_comb begin
    stateNxt = state;
    cntNxt   = last ? cnt : cnt - 1'b1;
    stb      = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            stateNxt = S_WSETUP;
            cntNxt   = CNT_W'(WSU_CYC - 1);
          end else begin
            stateNxt = S_READ;
            cntNxt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      S_READ: begin
        stb.select = 1'b1;
        stb.rdEn   = 1'b1;
        if (last) begin
          stb.capture = 1'b1;
          stb.done    = 1'b1;
          stateNxt    = S_TURN;
          cntNxt      = CNT_W'(TURN_CYC - 1);
        end
      end
      S_TURN: if (last) stateNxt = S_IDLE;
      S_WSETUP: begin
        stb.select = 1'b1;
        if (last) begin
          stateNxt = S_WPULSE;
          cntNxt   = CNT_W'(WPW_CYC - 1);
        end
      end
      S_WPULSE: begin
        stb.select = 1'b1;
        stb.wrEn   = 1'b1;
        stb.drive  = 1'b1;
        if (last) begin
          stateNxt = S_WHOLD;
          cntNxt   = CNT_W'(WHD_CYC - 1);
        end
      end
      S_WHOLD: begin
        stb.select = 1'b1;
        stb.drive  = 1'b1;
        if (last) begin
          stb.done = 1'b1;
          if (WREC_CYC > 0) begin
            stateNxt = S_WREC;
            cntNxt   = CNT_W'((WREC_CYC > 0) ? WREC_CYC - 1 : 0);
          end else begin
            stateNxt = S_IDLE;
          end
        end
      end
      S_WREC: if (last) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memBeN,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [LANES-1:0]  beQ;
  logic              ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
      ackQ   <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (stb.capture) rdataQ <= memDin;
      ackQ <= stb.done;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign memBeN[i] = ~(stb.select & beQ[i]);
  end

  assign memCe1N  = ~stb.select;
  assign memCe2   = stb.select;
  assign memOeN   = ~stb.rdEn;
  assign memWeN   = ~stb.wrEn;
  assign memDoe   = stb.drive;
  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign ackValid = ackQ;
  assign ackRdata = rdataQ;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 5,
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 16,
  parameter int T_RC    = 70,
  parameter int T_AA    = 70,
  parameter int T_DOE   = 35,
  parameter int T_WC    = 70,
  parameter int T_PWE   = 50,
  parameter int T_AW    = 60,
  parameter int T_SD    = 30,
  parameter int T_HD    = 0,
  parameter int T_HZOE  = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoe,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [1:0]        memBeN
);

  localparam int RD_CYC   = maxInt(nsToCycles(T_RC, CLK_NS),
                                   maxInt(nsToCycles(T_AA, CLK_NS), nsToCycles(T_DOE, CLK_NS)));
  localparam int TURN_CYC = nsToCycles(T_HZOE, CLK_NS);
  localparam int WPW_CYC  = maxInt(nsToCycles(T_PWE, CLK_NS), nsToCycles(T_SD, CLK_NS));
  localparam int WSU_CYC  = maxInt(1, nsToCycles(T_AW, CLK_NS) - WPW_CYC);
  localparam int WHD_CYC  = nsToCycles(T_HD, CLK_NS);
  localparam int WBODY    = WSU_CYC + WPW_CYC + WHD_CYC;
  localparam int WREC_CYC = maxInt(0, nsToCycles(T_WC, CLK_NS) - WBODY);

  strobe_t stb;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .WSU_CYC(WSU_CYC),
    .WPW_CYC(WPW_CYC), .WHD_CYC(WHD_CYC), .WREC_CYC(WREC_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(2)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN), .ackValid(ackValid), .ackRdata(ackRdata)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS = 5,
  parameter int T_HZOE = 25,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              ackValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoe,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [1:0]        memBeN
);

  localparam int TURN_CYC = nsToCycles(T_HZOE, CLK_NS);

  logic [7:0] sinceOe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sinceOe <= 8'hFF;
    else if (!memOeN) sinceOe <= '0;
    else if (sinceOe != 8'hFF) sinceOe <= sinceOe + 1'b1;
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && memBeN == 2'b11 && !memDoe));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  // R5
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R6
  we_end_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCe1N && memCe2 && memDoe));

  // R6
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDoe);

  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDout)));

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoe) |-> (sinceOe >= 8'(TURN_CYC)));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memDoe && !memOeN));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .CLK_NS(CLK_NS), .T_HZOE(T_HZOE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .ackValid(ackValid), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
  .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
  .memBeN(memBeN)
);

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        ackValid;
  logic [15:0] ackRdata;
  logic [18:0] memAddr;
  logic [15:0] memDout;
  logic [15:0] memDin;
  logic        memDoe, memCe1N, memCe2, memWeN, memOeN;
  logic [1:0]  memBeN;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .ackValid(ackValid), .ackRdata(ackRdata), .memAddr(memAddr), .memDout(memDout),
    .memDin(memDin), .memDoe(memDoe), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] memArr [logic [18:0]];
  int          rdCnt = 0;
  logic [15:0] word;

  always @(posedge clk)
    if (!memCe1N && memCe2 && !memOeN && memWeN) rdCnt <= rdCnt + 1;
    else rdCnt <= 0;

  always_comb begin
    word = memArr.exists(memAddr) ? memArr[memAddr] : 16'h0000;
    if (rdCnt >= 13)
      memDin = {memBeN[1] ? 8'h00 : word[15:8], memBeN[0] ? 8'h00 : word[7:0]};
    else
      memDin = 16'hBAD0;
  end

  always @(posedge memWeN)
    if (rstN && !memCe1N && memCe2 && memDoe) begin
      logic [15:0] w;
      w = memArr.exists(memAddr) ? memArr[memAddr] : 16'h0000;
      if (!memBeN[0]) w[7:0]  = memDout[7:0];
      if (!memBeN[1]) w[15:8] = memDout[15:8];
      memArr[memAddr] = w;
    end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          isWr;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t       sbQ[$];
  logic [15:0] shadow [logic [18:0]];

  task automatic doReq(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    item_t it;
    logic [15:0] cur;
    int busy;
    cur = shadow.exists(a) ? shadow[a] : 16'h0000;
    it.isWr = wr;
    it.tag  = tag;
    if (wr) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      shadow[a] = cur;
      it.exp = 16'h0;
    end else begin
      it.exp = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    sbQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    // R2: later changes to the request inputs must not affect this access
    reqAddr = ~a; reqWdata = ~d; reqBe = ~be; reqWrite = ~wr;
    chk(!reqReady, "R2 busy after accept", reqReady, 0);
    busy = 0;
    while (!reqReady) begin
      busy++;
      @(negedge clk);
    end
    // R8
    chk(busy >= 14, "R8 min cycle time", busy, 14);
  endtask

  // ---------------- pin monitor ----------------
  int  suCnt = 0, weCnt = 0, oeCnt = 0, sinceOe = 1000;
  bit  prevWe = 1'b1, prevDoe = 1'b0, prevAck = 1'b0;
  int  badIdle = 0, badOe = 0, badDrv = 0, badCont = 0;

  always @(negedge clk) if (rstN) begin
    if (ackValid) begin
      if (sbQ.size() == 0) chk(0, "R9 ack without request", 1, 0);
      else begin
        item_t it;
        it = sbQ.pop_front();
        if (!it.isWr) chk(ackRdata == it.exp, it.tag, ackRdata, it.exp);
        else          chk(1'b1, "R9 write ack", 1, 1);
      end
    end
    if (ackValid && prevAck) chk(0, "R3 ack longer than one cycle", 2, 1);
    prevAck = ackValid;

    if (reqReady && !(memCe1N && !memCe2 && memWeN && memOeN && memBeN == 2'b11 && !memDoe))
      badIdle++;
    if (memDoe && !memOeN) badCont++;

    // write setup / pulse / hold
    if (!memWeN && prevWe) begin
      chk(suCnt == 2, "R5 write setup cycles", suCnt, 2);
      suCnt = 0;
    end
    if (!memCe1N && memCe2 && memWeN && memOeN && !memDoe) suCnt++;
    else if (memCe1N) suCnt = 0;
    if (!memWeN) begin
      weCnt++;
      if (!memOeN) badOe++;
      if (!memDoe) badDrv++;
    end else if (weCnt > 0) begin
      chk(weCnt == 10, "R5 write pulse cycles", weCnt, 10);
      chk(!memCe1N && memCe2 && memDoe, "R6 hold after strobe", {memCe1N, memCe2, memDoe}, 3'b011);
      weCnt = 0;
    end
    prevWe = memWeN;

    // read strobe length and turnaround
    if (!memOeN) begin
      oeCnt++;
      sinceOe = 0;
    end else begin
      if (oeCnt > 0) chk(oeCnt == 14, "R3 read strobe cycles", oeCnt, 14);
      oeCnt = 0;
      if (sinceOe < 1000) sinceOe++;
    end
    if (memDoe && !prevDoe) chk(sinceOe >= 5, "R7 turnaround", sinceOe, 5);
    prevDoe = memDoe;
  end

  // ---------------- stimulus ----------------
  bit timedOut = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(memCe1N && !memCe2 && memWeN && memOeN && memBeN == 2'b11 && !memDoe && reqReady && !ackValid,
        "R1 reset standby", {memCe1N, memCe2, memWeN, memOeN, memDoe}, 5'b10110);
    rstN = 1'b1;
    fork
      begin
        doReq(1, 19'h00010, 16'h1234, 2'b11, "R9");
        doReq(0, 19'h00010, 16'h0,    2'b11, "R3 read full word");
        doReq(1, 19'h7FFFF, 16'hFFFF, 2'b11, "R9");
        doReq(1, 19'h7FFFF, 16'hABCD, 2'b01, "R4");
        doReq(1, 19'h7FFFF, 16'h5500, 2'b10, "R4");
        doReq(0, 19'h7FFFF, 16'h0,    2'b11, "R4 merged lanes");
        doReq(0, 19'h7FFFF, 16'h0,    2'b01, "R4 low lane read");
        doReq(0, 19'h7FFFF, 16'h0,    2'b10, "R4 high lane read");
        doReq(1, 19'h00000, 16'h0F0F, 2'b11, "R9");
        doReq(1, 19'h00001, 16'hF0F0, 2'b11, "R9");
        doReq(0, 19'h00000, 16'h0,    2'b11, "R2 address 0 kept");
        doReq(0, 19'h00001, 16'h0,    2'b11, "R2 address 1 kept");
        doReq(0, 19'h00010, 16'h0,    2'b11, "R3 read after other writes");
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) chk(0, "WATCHDOG", 1, 0);
    chk(sbQ.size() == 0, "R9 all requests acknowledged", sbQ.size(), 0);
    chk(badIdle == 0, "R1 standby when idle", badIdle, 0);
    chk(badOe == 0, "R5 output enable high in write", badOe, 0);
    chk(badDrv == 0, "R6 drivers on during strobe", badDrv, 0);
    chk(badCont == 0, "R10 no bus contention", badCont, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule